// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Controller

This block keeps the interrupt status of one DMA channel. It compares the channel's source and destination pointers with their programmed sizes and with half of those sizes. It also takes single-cycle pulses from the transfer engine for block completion, cell completion, abort and address error. Each of these eight conditions sets a sticky flag. Software clears a flag by writing zero to it.

One 32-bit register holds the eight flags and eight matching enables. The register has no address and is accessed with write data, byte-lane strobes and a read-back bus. One registered output requests an interrupt whenever an enabled flag is set. The transfer engine, address generation and interrupt prioritisation are outside this block.

Top module: `dma_chan_irq_ctrl`

## Requirements
- R1: After reset, every register bit reads 0 and `chan_irq` is low.
- R2: Flags are read in bits 7..0 in this order: bit 7 source done, bit 6 source half, bit 5 destination done, bit 4 destination half, bit 3 block complete, bit 2 cell complete, bit 1 abort, bit 0 address error. Each flag's enable sits at the flag's bit plus 16, in bits 23..16.
- R3: Bits 31..24 and 15..8 always read 0, and writes to them have no effect.
- R4: The source-done flag (bit 7) sets at the clock edge where `src_ptr == src_size` becomes true.
- R5: The source-half flag (bit 6) sets at the clock edge where `src_ptr == (src_size >> 1)` becomes true.
- R6: The destination-done flag (bit 5) sets at the clock edge where `dst_ptr == dst_size` becomes true.
- R7: The destination-half flag (bit 4) sets at the clock edge where `dst_ptr == (dst_size >> 1)` becomes true.
- R8: A one-cycle pulse on `evt_block_done`, `evt_cell_done`, `evt_abort` or `evt_addr_err` sets bit 3, 2, 1 or 0 at the next clock edge.
- R9: A compare flag sets only on the false-to-true transition of its condition. A pointer that stays on its threshold does not set the flag again after software has cleared it.
- R10: Flags hold their value until a write with lane 0 strobed loads bits 7..0. A hardware set in the same cycle as that write takes priority.
- R11: `chan_irq` equals the OR over all bits of (flag AND enable), registered. It rises one cycle after the edge that sets an enabled flag.
- R12: `reg_be[0]` gates writes to bits 7..0 and `reg_be[2]` gates writes to bits 23..16. A write with a lane's strobe low leaves that lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write request |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane write strobes |
| reg_rdata | output | 32 | Register read-back |
| src_ptr | input | PTR_W | Current source pointer |
| src_size | input | PTR_W | Programmed source size |
| dst_ptr | input | PTR_W | Current destination pointer |
| dst_size | input | PTR_W | Programmed destination size |
| evt_block_done | input | 1 | Block transfer complete pulse |
| evt_cell_done | input | 1 | Cell transfer complete pulse |
| evt_abort | input | 1 | Transfer abort pulse |
| evt_addr_err | input | 1 | Address error pulse |
| chan_irq | output | 1 | Channel interrupt request |

## Verification
The assertions assume the event inputs are single-cycle pulses. They also assume pointer and size values are stable between clock edges, so each compare has a clean false-to-true edge. The stimulus changes every input only at the falling clock edge. It keeps sizes at 4 or more, so a pointer of zero after reset never meets a threshold before it is meant to. Pointers mostly step by one toward the size, with occasional random jumps, so both gradual sweeps and abrupt edges reach the detectors.

// File: rtl/dma_irq_pkg.sv
// Package: shared layout constants for the DMA channel interrupt register.
// Assumes a 32-bit register with byte-wide lanes.
package dma_irq_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_FLAGS = 8;
    localparam int EN_BASE   = 16;
    localparam int BE_W      = REG_W / 8;
    localparam int FLAG_LANE = 0;
    localparam int EN_LANE   = EN_BASE / 8;
    localparam int NUM_CMP   = 4;

    // Flag bit positions inside bits 7..0
    typedef enum logic [2:0] {
        FLG_ADDR_ERR  = 3'd0,
        FLG_ABORT     = 3'd1,
        FLG_CELL      = 3'd2,
        FLG_BLOCK     = 3'd3,
        FLG_DST_HALF  = 3'd4,
        FLG_DST_DONE  = 3'd5,
        FLG_SRC_HALF  = 3'd6,
        FLG_SRC_DONE  = 3'd7
    } flag_pos_e;
endpackage

// File: rtl/ptr_threshold_det.sv
// Module: ptr_threshold_det
// Compares a pointer with a size, or with half of it (size >> 1), and
// emits a one-cycle pulse when the match turns from false to true.
// Assumes ptr and size are stable around the clock edge.
module ptr_threshold_det #(
    parameter int PTR_W     = 16,
    parameter bit HALF_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] size,
    output logic             hit_pulse
);
    logic [PTR_W-1:0] target;
    logic             match;
    logic             match_q;

    // Select the threshold that this instance watches
    generate
        if (HALF_MODE) begin : g_half
            assign target = size >> 1;
        end else begin : g_full
            assign target = size;
        end
    endgenerate

    // Current compare result
    assign match = (ptr == target);

    // Remember the previous compare result for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match;
        end
    end

    // Rising-edge pulse of the compare
    assign hit_pulse = match & ~match_q;
endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Holds the sticky flags and their enables. A write with the flag lane
// strobed loads the flags; a hardware set in the same cycle wins. A write
// with the enable lane strobed loads the enables.
// Assumes NUM_FLAGS fits in one byte lane.
module irq_flag_bank
    import dma_irq_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_flags,
    input  logic [N-1:0] wr_enables,
    input  logic         flag_lane_we,
    input  logic         en_lane_we,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables
);
    logic [N-1:0] flags_d;

    // Next flag value: software load or hold, then OR in hardware sets
    always_comb begin
        if (wr_en && flag_lane_we) begin
            flags_d = wr_flags;
        end else begin
            flags_d = flags;
        end
        flags_d = flags_d | hw_set;
    end

    // Flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_d;
        end
    end

    // Enable storage, loaded only through its own byte lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
        end else if (wr_en && en_lane_we) begin
            enables <= wr_enables;
        end
    end
endmodule

// File: rtl/irq_merge.sv
// Module: irq_merge
// Registers the OR over all (flag AND enable) pairs as one interrupt line.
// Assumes flags and enables come from registers.
module irq_merge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);
    // Registered request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |(flags & enables);
        end
    end
endmodule

// File: rtl/dma_chan_irq_ctrl.sv
// Module: dma_chan_irq_ctrl
// Per-channel DMA interrupt status and enable logic. Four flags come from
// pointer/size compares (done and half points of source and destination)
// and four from event pulses. All live in one address-less 32-bit register.
// Assumes event inputs are single-cycle pulses.
module dma_chan_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [BE_W-1:0]  reg_be,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [PTR_W-1:0] src_ptr,
    input  logic [PTR_W-1:0] src_size,
    input  logic [PTR_W-1:0] dst_ptr,
    input  logic [PTR_W-1:0] dst_size,
    input  logic             evt_block_done,
    input  logic             evt_cell_done,
    input  logic             evt_abort,
    input  logic             evt_addr_err,
    output logic             chan_irq
);
    logic [NUM_CMP-1:0]   cmp_hit;
    logic [NUM_FLAGS-1:0] hw_set;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] enables;

    // Compare detectors: index 0 src done, 1 src half, 2 dst done, 3 dst half
    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
            ptr_threshold_det #(
                .PTR_W    (PTR_W),
                .HALF_MODE((g % 2) == 1)
            ) u_det (
                .clk      (clk),
                .rst_n    (rst_n),
                .ptr      ((g < 2) ? src_ptr  : dst_ptr),
                .size     ((g < 2) ? src_size : dst_size),
                .hit_pulse(cmp_hit[g])
            );
            // Compare g drives flag bit (NUM_FLAGS-1-g)
            assign hw_set[NUM_FLAGS-1-g] = cmp_hit[g];
        end
    endgenerate

    // Event pulses into their flag positions
    assign hw_set[FLG_BLOCK]    = evt_block_done;
    assign hw_set[FLG_CELL]     = evt_cell_done;
    assign hw_set[FLG_ABORT]    = evt_abort;
    assign hw_set[FLG_ADDR_ERR] = evt_addr_err;

    irq_flag_bank #(
        .N(NUM_FLAGS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_flags    (reg_wdata[FLAG_LANE*8 +: NUM_FLAGS]),
        .wr_enables  (reg_wdata[EN_BASE +: NUM_FLAGS]),
        .flag_lane_we(reg_be[FLAG_LANE]),
        .en_lane_we  (reg_be[EN_LANE]),
        .hw_set      (hw_set),
        .flags       (flags),
        .enables     (enables)
    );

    irq_merge #(
        .N(NUM_FLAGS)
    ) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (flags),
        .enables(enables),
        .irq    (chan_irq)
    );

    // Read-back: implemented fields only, everything else zero
    always_comb begin
        reg_rdata = '0;
        reg_rdata[FLAG_LANE*8 +: NUM_FLAGS] = flags;
        reg_rdata[EN_BASE +: NUM_FLAGS]     = enables;
    end
endmodule

// File: rtl/dma_irq_chk.sv
// Module: dma_irq_chk
// Port-level checks for dma_chan_irq_ctrl, attached by bind.
// Assumes event inputs are single-cycle pulses.
module dma_irq_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [3:0]       reg_be,
    input logic [31:0]      reg_rdata,
    input logic [PTR_W-1:0] src_ptr,
    input logic [PTR_W-1:0] src_size,
    input logic             evt_abort,
    input logic             chan_irq
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:24] == 8'h0) && (reg_rdata[15:8] == 8'h0)); // R3

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (chan_irq == $past(|(reg_rdata[23:16] & reg_rdata[7:0])))); // R11

    AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_abort |=> reg_rdata[1]); // R8

    AST_SRC_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ptr == src_size) |=> reg_rdata[7]); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_be[0]) |=>
            ((reg_rdata[7:0] & $past(reg_rdata[7:0])) == $past(reg_rdata[7:0]))); // R10

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_be[2]) |=> $stable(reg_rdata[23:16])); // R12
endmodule

bind dma_chan_irq_ctrl dma_irq_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_be   (reg_be),
    .reg_rdata(reg_rdata),
    .src_ptr  (src_ptr),
    .src_size (src_size),
    .evt_abort(evt_abort),
    .chan_irq (chan_irq)
);

// File: tb/tb_dma_chan_irq_ctrl.sv
module tb_dma_chan_irq_ctrl;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [31:0]   wd = '0;
    logic [3:0]    be = '0;
    logic [31:0]   rd;
    logic [PW-1:0] sp = '0, ss = 16'd100, dp = '0, ds = 16'd100;
    logic          e_blk = 0, e_cell = 0, e_abt = 0, e_err = 0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [7:0] m_flags = '0, m_en = '0;
    logic       m_irq = 1'b0;
    logic [3:0] m_prev = '0;

    always #5 clk = ~clk;

    dma_chan_irq_ctrl #(.PTR_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_wdata(wd), .reg_be(be),
        .reg_rdata(rd), .src_ptr(sp), .src_size(ss), .dst_ptr(dp), .dst_size(ds),
        .evt_block_done(e_blk), .evt_cell_done(e_cell), .evt_abort(e_abt),
        .evt_addr_err(e_err), .chan_irq(irq)
    );

    function automatic logic [3:0] conds(input logic [PW-1:0] a, b, c, d);
        // bit 3 src done, 2 src half, 1 dst done, 0 dst half
        return {a == b, a == (b >> 1), c == d, c == (d >> 1)};
    endfunction

    function automatic logic [31:0] exp_reg(input logic [7:0] f, e);
        return {8'h00, e, 8'h00, f};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: predict, clock, compare (called at a falling edge)
    task automatic step(input string tag);
        logic [3:0] c;
        logic [7:0] set, nf;
        c   = conds(sp, ss, dp, ds);
        set = {c & ~m_prev, e_blk, e_cell, e_abt, e_err};
        nf  = (wr && be[0]) ? wd[7:0] : m_flags;
        nf  = nf | set;
        @(posedge clk);
        m_irq  = |(m_flags & m_en);
        m_flags = nf;
        if (wr && be[2]) m_en = wd[23:16];
        m_prev = c;
        @(negedge clk);
        chk(tag, rd, exp_reg(m_flags, m_en));
        chk(tag, {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic write(input logic [31:0] d, input logic [3:0] b, input string tag);
        wr = 1'b1; wd = d; be = b;
        step(tag);
        wr = 1'b0; wd = '0; be = '0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", rd, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);
        step("R1");

        // R4 R5: source sweep through half and full
        ss = 16'd10;
        step("R5");
        for (int i = 1; i <= 10; i++) begin
            sp = PW'(i);
            step(i == 5 ? "R5" : "R4");
        end
        chk("R4", {24'h0, rd[7:0] & 8'hC0}, 32'h000000C0);

        // R9: held at threshold, clear, must stay clear
        write(32'h0, 4'b0001, "R9");
        repeat (4) step("R9");
        chk("R9", {24'h0, rd[7:0]}, 32'h0);

        // R6 R7: destination sweep, size 9 so half is 4
        ds = 16'd9;
        for (int i = 1; i <= 9; i++) begin
            dp = PW'(i);
            step(i == 4 ? "R7" : "R6");
        end
        chk("R6", {24'h0, rd[7:0] & 8'h30}, 32'h00000030);

        // R8: event pulses
        e_blk = 1; step("R8"); e_blk = 0;
        e_cell = 1; step("R8"); e_cell = 0;
        e_abt = 1; e_err = 1; step("R8"); e_abt = 0; e_err = 0;
        chk("R8", {24'h0, rd[7:0] & 8'h0F}, 32'h0000000F);

        // R11: enables gate the interrupt, one cycle after flag
        chk("R11", {31'b0, irq}, 32'h0);
        write(32'h0002_0000, 4'b0100, "R11");
        step("R11");
        chk("R11", {31'b0, irq}, 32'h1);

        // R10: hardware set wins over a simultaneous clear
        e_abt = 1;
        write(32'h0, 4'b0001, "R10");
        e_abt = 0;
        chk("R10", {24'h0, rd[7:0]}, 32'h00000002);

        // R3 R12: writes with only unimplemented lanes strobed change nothing
        write(32'hFFFF_FFFF, 4'b1010, "R12");
        chk("R12", rd, 32'h0002_0002);
        write(32'hFFFF_FFFF, 4'b1111, "R3");
        chk("R3", rd, 32'h00FF_00FF);
        write(32'h0000_0000, 4'b0101, "R2");

        // R2: constrained random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 97 == 0) begin
                ss = PW'(4 + $urandom % 60); sp = '0;
                ds = PW'(4 + $urandom % 60); dp = '0;
            end
            if ($urandom % 9 == 0) sp = PW'($urandom % (ss + 2));
            else if (sp < ss + 1) sp = sp + 1'b1;
            if ($urandom % 9 == 0) dp = PW'($urandom % (ds + 2));
            else if (dp < ds + 1) dp = dp + 1'b1;
            e_blk  = ($urandom % 8 == 0);
            e_cell = ($urandom % 8 == 0);
            e_abt  = ($urandom % 8 == 0);
            e_err  = ($urandom % 8 == 0);
            if ($urandom % 6 == 0) write($urandom, 4'($urandom), "R2");
            else step("R2");
        end
        e_blk = 0; e_cell = 0; e_abt = 0; e_err = 0;
        step("R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule